// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Register Front End

This block is the digital side of a 12-bit voltage-output converter. A host writes the code in two byte-wide pieces over an 8-bit parallel bus. The low eight bits and the upper four bits go into separate holding latches, and each latch has its own bus address. A third address reaches a small control register. The control register selects the reference source and carries a speed bit, a power-down bit and a bit that makes the output register follow the holding latches.

The block combines the external speed, power and load pins with the matching control bits, one rule per function. From these it produces the effective speed mode, the power state and whether the output code follows or holds. It also drives the 12-bit code that feeds the resistor string and an encoded reference selection. Every bus and pin input is brought into the `clk` domain through a synchronizer. A write takes effect on the synchronized rising edge of the write strobe.

Top module: `dac_front`

## Requirements
- R1: A write is captured only on a rising edge of `wr_n` while `chip_sel_n` is low. A strobe with `chip_sel_n` high changes no latch and no control bit.
- R2: Address 0 loads `bus_data[7:0]` into the low holding latch, which becomes code bits 7..0. Address 1 loads `bus_data[3:0]` into the high holding latch, which becomes code bits 11..8, and data bits 7..4 are dropped.
- R3: Address 3 loads the control register from `bus_data[4:0]`. Bit 0 is the speed bit, bit 1 the power-down bit, bit 2 the follow bit, and bits 4:3 the reference select. Bits 7..5 are ignored.
- R4: A write to address 2 changes no holding latch and no control bit.
- R5: `fast_mode` is 1 when `speed_in` or control bit 0 is 1, and 0 only when both are 0.
- R6: `power_down` is 0 only when `power_in` is 1 and control bit 1 is 0. Every other combination gives 1.
- R7: The output code holds its value when `load_n` is high and control bit 2 is 0. Otherwise `code_open` is 1 and `code_out` follows {high latch, low latch}.
- R8: `ref_sel` is 0 (external) for reference-select values 00 and 11, 1 (high internal level) for 01, and 2 (low internal level) for 10. It never takes the value 3.
- R9: While reset is held, `code_out` and `ref_sel` are 0 and `code_open` and `fast_mode` are 0, and `power_down` is 1. All latches and the control register are cleared, so a later load with no writes gives code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; clears every latch and register |
| bus_data | input | 8 | Parallel write data |
| bus_addr | input | 2 | Destination select (0 low, 1 high, 3 control, 2 unused) |
| chip_sel_n | input | 1 | Active-low select that qualifies writes |
| wr_n | input | 1 | Active-low write strobe; its rising edge captures |
| load_n | input | 1 | Active-low load; low makes the output code follow |
| speed_in | input | 1 | Speed pin, 1 requests fast mode |
| power_in | input | 1 | Power pin, 1 requests normal operation |
| code_out | output | 12 | Converter code |
| fast_mode | output | 1 | Effective fast settling mode |
| power_down | output | 1 | Effective power-down state |
| code_open | output | 1 | Output register follows the holding latches |
| ref_sel | output | 2 | Encoded reference source |

## Verification
Pin inputs pass through two synchronizer stages. A change on `speed_in`, `power_in` or `load_n` therefore reaches `fast_mode`, `power_down` and `code_open` after two rising edges. A rising `wr_n` updates a holding latch or the control register on the third edge, and the following edge moves it into `code_out` when the output follows. The bench drives every input on the falling clock edge and, after each operation, waits at least four further cycles before it samples on a falling edge. The outputs have settled by then. The bench model updates its expected code only at these settle points, when the follow condition it computes itself is true.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  localparam int BUS_W  = 8;
  localparam int CODE_W = 12;
  localparam int CTL_W  = 5;
  localparam int ADDR_W = 2;

  // destination decode
  localparam logic [ADDR_W-1:0] ADR_LOW    = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_HIGH   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_UNUSED = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTL    = 2'd3;

  // control register field positions
  localparam int CB_SPEED = 0;
  localparam int CB_PDOWN = 1;
  localparam int CB_OPEN  = 2;
  localparam int CB_REF0  = 3;
  localparam int CB_REF1  = 4;

  typedef enum logic [1:0] {
    REF_EXTERNAL = 2'd0,
    REF_INT_HIGH = 2'd1,
    REF_INT_LOW  = 2'd2
  } ref_src_e;

  // fast unless both the pin and the bit ask for slow
  function automatic logic speed_fast(input logic pin, input logic bitv);
    return pin | bitv;
  endfunction

  // running only with the pin high and the bit clear
  function automatic logic powered_down(input logic pin, input logic bitv);
    return ~(pin & ~bitv);
  endfunction

  // output follows when the load pin is low or the follow bit is set
  function automatic logic code_follows(input logic load_pin_n, input logic bitv);
    return ~load_pin_n | bitv;
  endfunction

  function automatic ref_src_e ref_pick(input logic [1:0] code);
    case (code)
      2'b01:   return REF_INT_HIGH;
      2'b10:   return REF_INT_LOW;
      default: return REF_EXTERNAL;
    endcase
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= {STAGES{RST_VAL}};
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dacfe_wport.sv
module dacfe_wport
  import dacfe_pkg::*;
#(
  parameter int BUS_W_P = BUS_W,
  parameter int HI_W    = CODE_W - BUS_W,
  parameter int CTL_W_P = CTL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_n_s,
  input  logic               sel_n_s,
  input  logic [ADDR_W-1:0]  addr_s,
  input  logic [BUS_W_P-1:0] data_s,
  output logic [BUS_W_P-1:0] lo_q,
  output logic [HI_W-1:0]    hi_q,
  output logic [CTL_W_P-1:0] ctl_q,
  output logic               wr_strobe
);

  logic wr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= wr_n_s;
  end

  // rising edge of the synchronized strobe, qualified by select
  assign wr_strobe = wr_n_s & ~wr_prev & ~sel_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ctl_q <= '0;
    end else if (wr_strobe) begin
      case (addr_s)
        ADR_LOW:  lo_q  <= data_s;
        ADR_HIGH: hi_q  <= data_s[HI_W-1:0];
        ADR_CTL:  ctl_q <= data_s[CTL_W_P-1:0];
        default:  ;
      endcase
    end
  end

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> ($stable(lo_q) && $stable(hi_q) && $stable(ctl_q)));

  assert_low_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && addr_s == ADR_LOW) |=> (lo_q == $past(data_s) && $stable(hi_q)));

  assert_ctl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && addr_s == ADR_CTL) |=> (ctl_q == $past(data_s[CTL_W_P-1:0]) && $stable(lo_q)));

  assert_gap_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && addr_s == ADR_UNUSED) |=> ($stable(lo_q) && $stable(hi_q) && $stable(ctl_q)));

endmodule

// File: rtl/dacfe_modes.sv
module dacfe_modes
  import dacfe_pkg::*;
#(
  parameter int CTL_W_P = CTL_W
) (
  input  logic               speed_s,
  input  logic               power_s,
  input  logic               load_n_s,
  input  logic [CTL_W_P-1:0] ctl_q,
  output logic               fast_mode,
  output logic               power_down,
  output logic               code_open,
  output logic [1:0]         ref_sel
);

  ref_src_e ref_now;

  always_comb begin
    fast_mode  = speed_fast(speed_s, ctl_q[CB_SPEED]);
    power_down = powered_down(power_s, ctl_q[CB_PDOWN]);
    code_open  = code_follows(load_n_s, ctl_q[CB_OPEN]);
    ref_now    = ref_pick({ctl_q[CB_REF1], ctl_q[CB_REF0]});
    ref_sel    = ref_now;
  end

endmodule

// File: rtl/dacfe_codereg.sv
module dacfe_codereg #(
  parameter int CODE_W_P = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                open,
  input  logic [CODE_W_P-1:0] hold_word,
  output logic [CODE_W_P-1:0] code_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (open) code_q <= hold_word;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(code_q));

  assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    open |=> (code_q == $past(hold_word)));

endmodule

// File: rtl/dac_front.sv
module dac_front
  import dacfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              chip_sel_n,
  input  logic              wr_n,
  input  logic              load_n,
  input  logic              speed_in,
  input  logic              power_in,
  output logic [CODE_W-1:0] code_out,
  output logic              fast_mode,
  output logic              power_down,
  output logic              code_open,
  output logic [1:0]        ref_sel
);

  localparam int HI_W   = CODE_W - BUS_W;
  localparam int SYNC_W = 5 + ADDR_W + BUS_W;
  localparam logic [SYNC_W-1:0] SYNC_RST =
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, {ADDR_W{1'b0}}, {BUS_W{1'b0}}};

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic              wr_n_s, sel_n_s, load_n_s, speed_s, power_s;
  logic [ADDR_W-1:0] addr_s;
  logic [BUS_W-1:0]  data_s;
  logic [BUS_W-1:0]  lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              wr_strobe;

  assign raw_bus = {wr_n, chip_sel_n, load_n, speed_in, power_in, bus_addr, bus_data};
  assign {wr_n_s, sel_n_s, load_n_s, speed_s, power_s, addr_s, data_s} = sync_bus;

  dacfe_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  dacfe_wport #(.BUS_W_P(BUS_W), .HI_W(HI_W), .CTL_W_P(CTL_W)) u_wport (
    .clk(clk), .rst_n(rst_n), .wr_n_s(wr_n_s), .sel_n_s(sel_n_s),
    .addr_s(addr_s), .data_s(data_s), .lo_q(lo_q), .hi_q(hi_q),
    .ctl_q(ctl_q), .wr_strobe(wr_strobe)
  );

  dacfe_modes #(.CTL_W_P(CTL_W)) u_modes (
    .speed_s(speed_s), .power_s(power_s), .load_n_s(load_n_s), .ctl_q(ctl_q),
    .fast_mode(fast_mode), .power_down(power_down), .code_open(code_open),
    .ref_sel(ref_sel)
  );

  dacfe_codereg #(.CODE_W_P(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .open(code_open), .hold_word({hi_q, lo_q}),
    .code_q(code_out)
  );

  assert_fast_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    speed_s |-> fast_mode);

  assert_slow_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_mode |-> (!speed_s && !ctl_q[CB_SPEED]));

  assert_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !power_down |-> (power_s && !ctl_q[CB_PDOWN]));

  assert_ref_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel != 2'd3);

endmodule

// File: tb/sim_dac_front.sv
`timescale 1ns/1ps
module sim_dac_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_data = '0;
  logic [1:0]  bus_addr = '0;
  logic        chip_sel_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        load_n = 1'b1;
  logic        speed_in = 1'b0;
  logic        power_in = 1'b1;
  logic [11:0] code_out;
  logic        fast_mode, power_down, code_open;
  logic [1:0]  ref_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [7:0]  m_lo = '0;
  logic [3:0]  m_hi = '0;
  logic [4:0]  m_ctl = '0;
  logic [11:0] m_code = '0;

  always #10 clk = ~clk;

  dac_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .chip_sel_n(chip_sel_n), .wr_n(wr_n), .load_n(load_n), .speed_in(speed_in),
    .power_in(power_in), .code_out(code_out), .fast_mode(fast_mode),
    .power_down(power_down), .code_open(code_open), .ref_sel(ref_sel)
  );

  function automatic logic exp_fast();
    return !(speed_in == 1'b0 && m_ctl[0] == 1'b0);
  endfunction

  function automatic logic exp_pd();
    if (power_in == 1'b1 && m_ctl[1] == 1'b0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_open();
    if (load_n == 1'b1 && m_ctl[2] == 1'b0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [1:0] exp_ref();
    if (m_ctl[4:3] == 2'b01) return 2'd1;
    if (m_ctl[4:3] == 2'b10) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    if (exp_open()) m_code = {m_hi, m_lo};
  endtask

  task automatic check_all(input string ctx);
    check({"R7 code ", ctx}, code_out, m_code);
    check({"R7 open ", ctx}, code_open, exp_open());
    check({"R5 fast ", ctx}, fast_mode, exp_fast());
    check({"R6 pdown ", ctx}, power_down, exp_pd());
    check({"R8 ref ", ctx}, ref_sel, exp_ref());
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_low);
    @(negedge clk);
    chip_sel_n = ~sel_low;
    bus_addr = a;
    bus_data = d;
    repeat (3) @(negedge clk);
    wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    chip_sel_n = 1'b1;
    if (sel_low) begin
      case (a)
        2'd0: m_lo = d;
        2'd1: m_hi = d[3:0];
        2'd3: m_ctl = d[4:0];
        default: ;
      endcase
    end
    settle(4);
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load_n = 1'b0;
    settle(4);
    load_n = 1'b1;
    settle(4);
  endtask

  task automatic set_pins(input logic s, input logic p);
    @(negedge clk);
    speed_in = s;
    power_in = p;
    settle(4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_lo = '0; m_hi = '0; m_ctl = '0; m_code = '0;
    repeat (3) @(negedge clk);
    // R9: reset state while held
    check("R9 code in reset", code_out, 0);
    check("R9 ref in reset", ref_sel, 0);
    check("R9 open in reset", code_open, 0);
    check("R9 fast in reset", fast_mode, 0);
    check("R9 pdown in reset", power_down, 1);
    rst_n = 1'b1;
    settle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    do_reset();
    check_all("after reset");

    // R9: cleared latches load as zero
    pulse_load();
    check("R9 cleared latches", code_out, 0);

    // R2 / R7: held until load
    bus_write(2'd0, 8'hA5, 1'b1);
    check("R7 held after low write", code_out, 12'h000);
    bus_write(2'd1, 8'h3C, 1'b1);
    check("R7 held after high write", code_out, 12'h000);
    pulse_load();
    check("R2 split halves", code_out, 12'hCA5);

    // R1: deselected write ignored
    bus_write(2'd0, 8'hFF, 1'b0);
    pulse_load();
    check("R1 deselected write", code_out, 12'hCA5);

    // R4: address 2 ignored
    bus_write(2'd2, 8'h1F, 1'b1);
    pulse_load();
    check("R4 code after addr2", code_out, 12'hCA5);
    check("R4 ref after addr2", ref_sel, 0);
    check("R4 fast after addr2", fast_mode, 0);
    check("R4 pdown after addr2", power_down, 0);

    // R3 / R7: follow bit makes output transparent
    bus_write(2'd3, 8'h04, 1'b1);
    check("R3 follow bit open", code_open, 1);
    bus_write(2'd0, 8'h12, 1'b1);
    check("R7 transparent follow", code_out, 12'hC12);

    // R3 / R5 / R8: upper bits ignored, fields decoded
    bus_write(2'd3, 8'hE9, 1'b1);
    check("R3 speed bit", fast_mode, 1);
    check("R8 ref 01", ref_sel, 1);
    check("R3 follow cleared", code_open, 0);
    bus_write(2'd3, 8'h12, 1'b1);
    check("R8 ref 10", ref_sel, 2);
    check("R6 pdown bit", power_down, 1);
    bus_write(2'd3, 8'h18, 1'b1);
    check("R8 ref 11 external", ref_sel, 0);

    // R5 / R6 pin combinations
    bus_write(2'd3, 8'h00, 1'b1);
    for (int k = 0; k < 4; k++) begin
      set_pins(k[0], k[1]);
      check("R5 pin speed", fast_mode, k[0]);
      check("R6 pin power", power_down, !k[1]);
    end

    // R7: load held low stays transparent
    @(negedge clk);
    load_n = 1'b0;
    settle(4);
    bus_write(2'd1, 8'hF7, 1'b1);
    check("R7 load low follow", code_out, 12'h712);
    @(negedge clk);
    load_n = 1'b1;
    settle(4);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: bus_write(2'($urandom % 4), 8'($urandom), ($urandom % 5) != 0);
        1: set_pins(1'($urandom), 1'($urandom));
        2: pulse_load();
        default: begin
          @(negedge clk);
          load_n = 1'($urandom);
          settle(4);
        end
      endcase
      check_all("random");
    end

    // R9: reset in mid-run clears everything
    @(negedge clk);
    load_n = 1'b1;
    do_reset();
    pulse_load();
    check("R9 code cleared by reset", code_out, 0);
    check_all("final");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule